// File: doc/BRIEF.md
# Motor Controller Interrupt Flag Unit

This block collects ten motor-control event sources into latched status flags, holds their enable bits and turns each enabled flag into an interrupt request. The ten sources are:

- ratio increment and ratio decrement;
- commutation/capture;
- zero-crossing;
- end of demagnetisation;
- current limitation;
- emergency stop;
- PWM update;
- speed error;
- sampling out.

Hardware raises a flag with a one-cycle pulse on `evtSet`. Software clears a flag by writing a zero to its bit. Writing a one to a bit leaves that flag alone.

One write value on the main status register is a command, not a clear. All ones (FFh) sets the PWM-update flag and sends a one-cycle resynchronisation request to the PWM timer. A following write of 7Fh drops the PWM-update flag again. The two ratio events share one enable bit. In switched commutation mode, a ratio increment and a ratio decrement that arrive together cancel each other.

Power modes are handled at the edge of the block. Any enabled flag drives a wake request for the wait mode, and the global mask does not affect it. In halt mode every register is frozen and no wake request is given.

Register map (`wrAddr`/`rdAddr`):

| Address | Register | Bits |
|---|---|---|
| 0 | main status | bit0 ratio increment, bit1 ratio decrement, bit2 commutation, bit3 zero-crossing, bit4 demagnetisation, bit5 current limit, bit6 emergency stop, bit7 PWM update |
| 1 | aux status | bit0 speed error, bit1 sampling out |
| 2 | main enable | same bit positions as main status, except bit0 enables both ratio events and bit1 is unused |
| 3 | aux enable | same bit positions as aux status |

`evtSet` index k and `irqReq` index k are source k. Main-status bits give k = 0..7 and aux-status bits 0..1 give k = 8..9.

Top module: `mc_irq_flag_unit`

## Requirements
- R1: `irqReq[k]` is high exactly when flag k is set, its enable bit is set and `globalMask` is low. With `globalMask` high, all of `irqReq` is zero.
- R2: Enable bit 0 of the main enable register (address 2) enables both the ratio increment (k=0) and ratio decrement (k=1) requests. Bit 1 of that register always reads 0.
- R3: A write of FFh to address 0 outside halt sets main status bit 7 (PWM update) and leaves every other flag unchanged. `resyncReq` is high for the one cycle after the write edge.
- R4: Any other write to a status register (address 0 or 1) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A write of 7Fh to address 0 therefore clears only bit 7.
- R5: With `switchedMode` high, ratio increment and ratio decrement pulses in the same cycle set neither flag. With `switchedMode` low, they set both flags.
- R6: `wakeFromWait` is high whenever any flag is set together with its enable bit, whatever the value of `globalMask`.
- R7: While `haltMode` is high, the following are all ignored: event pulses, register writes and the FFh command. No flag or enable changes and `resyncReq` stays low.
- R8: While `haltMode` is high, `wakeFromWait` is low.
- R9: If a hardware event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R10: After reset, all flags and enables read 0, and `irqReq`, `wakeFromWait` and `resyncReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read data (combinational) |
| evtSet | input | 10 | One-cycle event pulses, one per source |
| switchedMode | input | 1 | Switched commutation mode |
| globalMask | input | 1 | Global interrupt mask, high blocks requests |
| haltMode | input | 1 | Halt power mode, freezes the block |
| irqReq | output | 10 | Per-source interrupt request |
| wakeFromWait | output | 1 | Wake request for the wait power mode |
| resyncReq | output | 1 | One-cycle timer resynchronisation request |

## Verification
The request logic is exercised with enable, mask and flag patterns that separate the AND of all three from any OR-like or mask-ignoring variant. The wait-mode wake is checked against the mask on its own, so that the two outputs cannot be mixed up. The ratio pair is driven together in both commutation modes, which tells the collision drop apart from a missing or always-on drop. The status register receives FFh, 7Fh, zero and a zero arriving in the same cycle as an event: these separate the command from an ordinary write, bit-wise clearing from a whole-register clear, and set priority from clear priority. Halt is entered with a flag already enabled, so freezing and wake gating are both visible.

// File: rtl/mc_irq_pkg.sv
package mc_irq_pkg;
  localparam int NUM_SRC   = 10;
  localparam int MAIN_BITS = 8;
  localparam int AUX_BITS  = NUM_SRC - MAIN_BITS;

  localparam int IDX_RATIO_INC = 0;
  localparam int IDX_RATIO_DEC = 1;
  localparam int IDX_PWM_UPD   = 7;

  localparam int ADR_MAIN_STAT = 0;
  localparam int ADR_AUX_STAT  = 1;
  localparam int ADR_MAIN_EN   = 2;
  localparam int ADR_AUX_EN    = 3;

  localparam logic [MAIN_BITS-1:0] CMD_RESYNC = '1;

  typedef struct packed {
    logic clrMain;
    logic clrAux;
    logic loadMainEn;
    logic loadAuxEn;
    logic resyncCmd;
    logic freeze;
    logic ratioDrop;
  } mcStrobe_t;
endpackage

// File: rtl/mc_irq_ctrl.sv
module mc_irq_ctrl
  import mc_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [MAIN_BITS-1:0] wrData,
  input  logic [1:0]           ratioEvt,
  input  logic                 switchedMode,
  input  logic                 haltMode,
  output mcStrobe_t            strb,
  output logic                 resyncReq
);
  logic liveWr;
  logic isCmd;
  logic resyncQ;

  assign liveWr = wrEn & ~haltMode;
  assign isCmd  = (wrData == CMD_RESYNC);

  always_comb begin
    strb            = '0;
    strb.freeze     = haltMode;
    strb.ratioDrop  = switchedMode & ratioEvt[0] & ratioEvt[1];
    strb.clrMain    = liveWr & (wrAddr == ADDR_W'(ADR_MAIN_STAT)) & ~isCmd;
    strb.resyncCmd  = liveWr & (wrAddr == ADDR_W'(ADR_MAIN_STAT)) & isCmd;
    strb.clrAux     = liveWr & (wrAddr == ADDR_W'(ADR_AUX_STAT));
    strb.loadMainEn = liveWr & (wrAddr == ADDR_W'(ADR_MAIN_EN));
    strb.loadAuxEn  = liveWr & (wrAddr == ADDR_W'(ADR_AUX_EN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resyncQ <= 1'b0;
    else        resyncQ <= strb.resyncCmd;
  end

  assign resyncReq = resyncQ;

  AST_HALT_NO_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    haltMode |=> !resyncReq); // R7
  AST_CMD_NOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.resyncCmd && strb.clrMain)); // R3
endmodule

// File: rtl/mc_irq_dp.sv
module mc_irq_dp
  import mc_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mcStrobe_t            strb,
  input  logic [MAIN_BITS-1:0] wrData,
  input  logic [NUM_SRC-1:0]   evtSet,
  input  logic                 globalMask,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [MAIN_BITS-1:0] rdData,
  output logic [NUM_SRC-1:0]   irqReq,
  output logic                 wakeFromWait
);
  logic [NUM_SRC-1:0]   flagQ, flagD;
  logic [MAIN_BITS-1:0] enMainQ;
  logic [AUX_BITS-1:0]  enAuxQ;
  logic [NUM_SRC-1:0]   srcEn;
  logic [NUM_SRC-1:0]   active;

  localparam logic [MAIN_BITS-1:0] MAIN_EN_MASK = ~(MAIN_BITS'(1) << IDX_RATIO_DEC);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    logic setK;
    logic keepK;
    if (k < MAIN_BITS) begin : g_main
      assign keepK = ~strb.clrMain | wrData[k];
    end else begin : g_aux
      assign keepK = ~strb.clrAux | wrData[k-MAIN_BITS];
    end
    if (k == IDX_RATIO_INC || k == IDX_RATIO_DEC) begin : g_ratio
      assign setK = evtSet[k] & ~strb.ratioDrop;
    end else if (k == IDX_PWM_UPD) begin : g_pwm
      assign setK = evtSet[k] | strb.resyncCmd;
    end else begin : g_plain
      assign setK = evtSet[k];
    end
    assign flagD[k] = strb.freeze ? flagQ[k] : ((flagQ[k] & keepK) | setK);

    if (k == IDX_RATIO_INC || k == IDX_RATIO_DEC) begin : g_en_ratio
      assign srcEn[k] = enMainQ[IDX_RATIO_INC];
    end else if (k < MAIN_BITS) begin : g_en_main
      assign srcEn[k] = enMainQ[k];
    end else begin : g_en_aux
      assign srcEn[k] = enAuxQ[k-MAIN_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagQ   <= '0;
      enMainQ <= '0;
      enAuxQ  <= '0;
    end else begin
      flagQ <= flagD;
      if (strb.loadMainEn && !strb.freeze) enMainQ <= wrData & MAIN_EN_MASK;
      if (strb.loadAuxEn && !strb.freeze)  enAuxQ  <= wrData[AUX_BITS-1:0];
    end
  end

  assign active       = flagQ & srcEn;
  assign irqReq       = globalMask ? '0 : active;
  assign wakeFromWait = ~strb.freeze & (|active);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(ADR_MAIN_STAT): rdData = flagQ[MAIN_BITS-1:0];
      ADDR_W'(ADR_AUX_STAT):  rdData = MAIN_BITS'(flagQ[NUM_SRC-1:MAIN_BITS]);
      ADDR_W'(ADR_MAIN_EN):   rdData = enMainQ;
      ADDR_W'(ADR_AUX_EN):    rdData = MAIN_BITS'(enAuxQ);
      default:                rdData = '0;
    endcase
  end

  AST_REQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq != '0) |-> !globalMask); // R1
  AST_RATIO_SHARED_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !enMainQ[IDX_RATIO_DEC]); // R2
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.freeze |=> ($stable(flagQ) && $stable(enMainQ) && $stable(enAuxQ))); // R7
  AST_COLLISION_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ratioDrop && !strb.clrMain) |=> $stable(flagQ[1:0])); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evtSet[2] && !strb.freeze) |=> flagQ[2]); // R9
  AST_WAKE_IGNORES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq != '0 && !strb.freeze) |-> wakeFromWait); // R6
  AST_HALT_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.freeze |-> !wakeFromWait); // R8
endmodule

// File: rtl/mc_irq_flag_unit.sv
module mc_irq_flag_unit
  import mc_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [MAIN_BITS-1:0] wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [MAIN_BITS-1:0] rdData,
  input  logic [NUM_SRC-1:0]   evtSet,
  input  logic                 switchedMode,
  input  logic                 globalMask,
  input  logic                 haltMode,
  output logic [NUM_SRC-1:0]   irqReq,
  output logic                 wakeFromWait,
  output logic                 resyncReq
);
  mcStrobe_t strb;

  mc_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .ratioEvt     (evtSet[IDX_RATIO_DEC:IDX_RATIO_INC]),
    .switchedMode (switchedMode),
    .haltMode     (haltMode),
    .strb         (strb),
    .resyncReq    (resyncReq)
  );

  mc_irq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .wrData       (wrData),
    .evtSet       (evtSet),
    .globalMask   (globalMask),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .irqReq       (irqReq),
    .wakeFromWait (wakeFromWait)
  );

  AST_RESYNC_SETS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (resyncReq && rdAddr == ADDR_W'(ADR_MAIN_STAT)) |-> rdData[IDX_PWM_UPD]); // R3
endmodule

// File: tb/mc_irq_flag_unit_tb_top.sv
module mc_irq_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [9:0] evtSet = '0;
  logic       switchedMode = 1'b0;
  logic       globalMask = 1'b0;
  logic       haltMode = 1'b0;
  logic [9:0] irqReq;
  logic       wakeFromWait;
  logic       resyncReq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mc_irq_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtSet(evtSet), .switchedMode(switchedMode),
    .globalMask(globalMask), .haltMode(haltMode), .irqReq(irqReq),
    .wakeFromWait(wakeFromWait), .resyncReq(resyncReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [9:0] v);
    @(negedge clk);
    evtSet = v;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic clearAll();
    doWrite(2'd0, 8'h00);
    doWrite(2'd1, 8'h00);
    doWrite(2'd2, 8'h00);
    doWrite(2'd3, 8'h00);
  endtask

  task automatic tReset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], d);
      chk("R10 register after reset", d, 0);
    end
    chk("R10 irqReq after reset", irqReq, 0);
    chk("R10 wake after reset", wakeFromWait, 0);
    chk("R10 resync after reset", resyncReq, 0);
  endtask

  task automatic tEnableMask();
    clearAll();
    globalMask = 1'b0;
    pulseEvt(10'h008);
    chk("R1 flag without enable gives no request", irqReq, 0);
    chk("R6 flag without enable gives no wake", wakeFromWait, 0);
    doWrite(2'd2, 8'h08);
    chk("R1 enabled unmasked request", irqReq, 10'h008);
    chk("R6 wake with enabled flag", wakeFromWait, 1);
    globalMask = 1'b1;
    #1;
    chk("R1 mask blocks request", irqReq, 0);
    chk("R6 wake ignores mask", wakeFromWait, 1);
    globalMask = 1'b0;
    doWrite(2'd3, 8'h02);
    pulseEvt(10'h200);
    chk("R1 aux source request", irqReq, 10'h208);
    doWrite(2'd2, 8'h00);
    chk("R1 disable removes request", irqReq, 10'h200);
  endtask

  task automatic tSharedEnable();
    logic [7:0] d;
    clearAll();
    switchedMode = 1'b0;
    pulseEvt(10'h003);
    readReg(2'd0, d);
    chk("R5 non-switched pair sets both", d, 8'h03);
    doWrite(2'd2, 8'h01);
    chk("R2 shared enable drives both ratio requests", irqReq, 10'h003);
    doWrite(2'd2, 8'h02);
    readReg(2'd2, d);
    chk("R2 bit1 of main enable reads zero", d, 8'h00);
    chk("R2 bit1 enables nothing", irqReq, 0);
  endtask

  task automatic tSwitched();
    logic [7:0] d;
    clearAll();
    switchedMode = 1'b1;
    pulseEvt(10'h003);
    readReg(2'd0, d);
    chk("R5 switched collision dropped", d, 8'h00);
    pulseEvt(10'h002);
    readReg(2'd0, d);
    chk("R5 switched single event kept", d, 8'h02);
    switchedMode = 1'b0;
  endtask

  task automatic tResync();
    logic [7:0] d;
    clearAll();
    pulseEvt(10'h108);
    doWrite(2'd0, 8'hFF);
    chk("R3 resync pulse after FF write", resyncReq, 1);
    readReg(2'd0, d);
    chk("R3 FF sets PWM flag only", d, 8'h88);
    readReg(2'd1, d);
    chk("R3 FF leaves aux flags", d, 8'h01);
    @(negedge clk);
    chk("R3 resync lasts one cycle", resyncReq, 0);
    doWrite(2'd0, 8'h7F);
    readReg(2'd0, d);
    chk("R4 7F clears only bit7", d, 8'h08);
    chk("R4 plain write gives no resync", resyncReq, 0);
    pulseEvt(10'h030);
    doWrite(2'd0, 8'hDF);
    readReg(2'd0, d);
    chk("R4 zero bit clears, one bit keeps", d, 8'h18);
    doWrite(2'd1, 8'hFE);
    readReg(2'd1, d);
    chk("R4 aux write clears bit0", d, 8'h00);
  endtask

  task automatic tSetWins();
    logic [7:0] d;
    clearAll();
    pulseEvt(10'h014);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h00; evtSet = 10'h004;
    @(negedge clk);
    wrEn = 1'b0; evtSet = '0;
    readReg(2'd0, d);
    chk("R9 set beats same-cycle clear", d, 8'h04);
  endtask

  task automatic tHalt();
    logic [7:0] d;
    clearAll();
    doWrite(2'd2, 8'h08);
    pulseEvt(10'h008);
    chk("R6 wake before halt", wakeFromWait, 1);
    @(negedge clk);
    haltMode = 1'b1;
    #1;
    chk("R8 no wake in halt", wakeFromWait, 0);
    pulseEvt(10'h010);
    doWrite(2'd0, 8'hFF);
    chk("R7 no resync in halt", resyncReq, 0);
    doWrite(2'd0, 8'h00);
    doWrite(2'd2, 8'hFF);
    readReg(2'd0, d);
    chk("R7 flags frozen in halt", d, 8'h08);
    readReg(2'd2, d);
    chk("R7 enables frozen in halt", d, 8'h08);
    @(negedge clk);
    haltMode = 1'b0;
    #1;
    chk("R8 wake returns after halt", wakeFromWait, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tEnableMask();
    tSharedEnable();
    tSwitched();
    tResync();
    tSetWins();
    tHalt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule